// File: doc/BRIEF.md
# Operand Wait Station with Tag Renaming

This block sits between the decode stage and one function unit of a dynamically scheduled core. It keeps three kinds of state: a small station of instructions waiting for their operands, a pool of free result tags, and a status record for each architectural register. The status record says whether the register holds its latest value or is waiting for a tag. When an instruction is accepted, its destination register is renamed to a fresh tag. Each of its two sources is resolved either to a value or to the tag of the instruction that will produce it.

A completing function unit sends one result broadcast, a tag plus a value. That broadcast does three things at once. It wakes every waiting source that holds the tag. It updates the register only if the register still names that tag. It returns the tag to the pool. Whenever the function unit signals that it is free, the lowest-indexed entry with both operands present leaves the station, and its slot is freed. A lookup port shows the status of any one register so that the rename state can be observed.

Top module: `tagsched_station`

## Requirements
- R1: After reset every register reads ready with value 0 and tag 0, every tag is free, and the station is empty: disp_ready is 1, disp_tag is 0 and issue_valid is 0.
- R2: disp_tag always shows the lowest-numbered free tag. A dispatch is accepted on a clock edge where disp_valid and disp_ready are both 1, and the accepted instruction takes that tag as its destination tag.
- R3: From the cycle after an accepted dispatch, the destination register reads not ready, holding the assigned tag.
- R4: Each source is resolved when the instruction is dispatched, from the register state before that instruction's own rename. A ready register supplies its value. A pending register supplies its tag and leaves the operand waiting.
- R5: A broadcast (bcast_valid=1) marks every waiting operand whose tag equals bcast_tag as ready and stores bcast_value in it. An entry woken this way can issue in the next cycle.
- R6: When a dispatch reads a pending source whose tag is being broadcast in the same cycle, the source takes the broadcast value and is ready at once.
- R7: A broadcast writes bcast_value into a register, and marks it ready, only if that register is pending under bcast_tag. Registers renamed to a newer tag are left pending. The broadcast tag becomes free again from the next cycle.
- R8: When fu_ready is 1 and at least one entry has both operands ready, issue_valid is 1 and the outputs carry the opcode, destination tag and operands of the lowest-indexed such entry. That entry is freed at the clock edge. When fu_ready is 0, issue_valid is 0.
- R9: disp_ready is 0 while all 4 station entries are occupied or no tag is free. A disp_valid in that state changes no register or station state.
- R10: If a dispatch renames a register in the same cycle as a broadcast of that register's old tag, the rename wins: the register stays pending under the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_op | input | 4 | Opcode of the offered instruction |
| disp_dst | input | 3 | Destination register number |
| disp_src_a | input | 3 | First source register number |
| disp_src_b | input | 3 | Second source register number |
| disp_ready | output | 1 | Station slot and free tag both available |
| disp_tag | output | 3 | Tag the offered instruction would receive |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | 3 | Tag of the broadcast result |
| bcast_value | input | 32 | Broadcast result value |
| fu_ready | input | 1 | Function unit can accept an instruction |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_op | output | 4 | Opcode of the issued instruction |
| issue_tag | output | 3 | Destination tag of the issued instruction |
| issue_a | output | 32 | First operand value |
| issue_b | output | 32 | Second operand value |
| look_idx | input | 3 | Register selected for lookup |
| look_ready | output | 1 | Selected register holds its latest value |
| look_tag | output | 3 | Tag the selected register waits on |
| look_value | output | 32 | Value of the selected register |

## Verification
The bench aims at the cycle where rename and broadcast collide. A source read in that cycle must take the broadcast value; a design that missed this would leave the consumer waiting forever on a tag that has already been freed. A register renamed twice must ignore the result of the older producer; a design that skipped the tag compare would show a stale value as ready. A source that names its own destination must read the old value, not its own new tag, or the instruction would deadlock. The bench also fills the station and then drains the tag pool. A design that stalled on only one of those two conditions would overwrite an entry or hand the same tag to two producers.

// File: rtl/tagsched_pkg.sv
package tagsched_pkg;
    localparam int TS_NUM_ENTRIES = 4;
    localparam int TS_NUM_TAGS    = 8;
    localparam int TS_NUM_REGS    = 8;
    localparam int TS_DATA_W      = 32;
    localparam int TS_OP_W        = 4;
    localparam int TS_NUM_SRC     = 2;
endpackage

// File: rtl/ts_tag_pool.sv
module ts_tag_pool #(
    parameter int NUM_TAGS = tagsched_pkg::TS_NUM_TAGS,
    parameter int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_en,
    input  logic             give_en,
    input  logic [TAG_W-1:0] give_tag,
    output logic             any_free,
    output logic [TAG_W-1:0] next_tag
);
    typedef struct packed {
        logic [NUM_TAGS-1:0] free;
    } pool_state_t;

    pool_state_t st_q, st_d;
    logic [TAG_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (st_q.free[i]) pick = TAG_W'(i);
        end
        st_d = st_q;
        if (take_en) st_d.free[pick] = 1'b0;
        if (give_en) st_d.free[give_tag] = 1'b1;
    end

    assign any_free = |st_q.free;
    assign next_tag = pick;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.free <= '1;
        else        st_q <= st_d;
    end

    // R2: a taken tag leaves the pool
    assert_tag_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |=> !st_q.free[$past(pick)]);
    // R7: a broadcast tag must be in use, and comes back to the pool
    assert_bcast_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        give_en |-> !st_q.free[give_tag]);
    assert_tag_returned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        give_en |=> st_q.free[$past(give_tag)]);
endmodule

// File: rtl/ts_reg_status.sv
module ts_reg_status #(
    parameter int NUM_REGS = tagsched_pkg::TS_NUM_REGS,
    parameter int NUM_TAGS = tagsched_pkg::TS_NUM_TAGS,
    parameter int DATA_W   = tagsched_pkg::TS_DATA_W,
    parameter int NUM_SRC  = tagsched_pkg::TS_NUM_SRC,
    parameter int REG_W    = $clog2(NUM_REGS),
    parameter int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src_idx   [NUM_SRC],
    output logic              src_ready [NUM_SRC],
    output logic [TAG_W-1:0]  src_tag   [NUM_SRC],
    output logic [DATA_W-1:0] src_value [NUM_SRC],
    input  logic              ren_en,
    input  logic [REG_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic [REG_W-1:0]  look_idx,
    output logic              look_ready,
    output logic [TAG_W-1:0]  look_tag,
    output logic [DATA_W-1:0] look_value
);
    typedef struct packed {
        logic              ready;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } reg_rec_t;

    typedef struct packed {
        reg_rec_t [NUM_REGS-1:0] r;
    } rf_state_t;

    rf_state_t st_q, st_d;

    // source resolution, with bypass of a same-cycle broadcast
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        reg_rec_t cur;
        assign cur = st_q.r[src_idx[s]];
        always_comb begin
            src_tag[s] = cur.tag;
            if (cur.ready) begin
                src_ready[s] = 1'b1;
                src_value[s] = cur.value;
            end else if (bc_valid && (bc_tag == cur.tag)) begin
                src_ready[s] = 1'b1;
                src_value[s] = bc_value;
            end else begin
                src_ready[s] = 1'b0;
                src_value[s] = '0;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (ren_en && (ren_idx == REG_W'(r))) begin
                st_d.r[r].ready = 1'b0;
                st_d.r[r].tag   = ren_tag;
            end else if (bc_valid && !st_q.r[r].ready && (st_q.r[r].tag == bc_tag)) begin
                st_d.r[r].ready = 1'b1;
                st_d.r[r].value = bc_value;
            end
        end
    end

    assign look_ready = st_q.r[look_idx].ready;
    assign look_tag   = st_q.r[look_idx].tag;
    assign look_value = st_q.r[look_idx].value;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                st_q.r[r].ready <= 1'b1;
                st_q.r[r].tag   <= '0;
                st_q.r[r].value <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R3: renamed destination is pending under its new tag
    assert_dst_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ren_en |=> (!st_q.r[$past(ren_idx)].ready && st_q.r[$past(ren_idx)].tag == $past(ren_tag)));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        // R7: a broadcast of a tag the register no longer names leaves its value alone
        assert_stale_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && !st_q.r[r].ready && st_q.r[r].tag != bc_tag && !(ren_en && ren_idx == REG_W'(r)))
            |=> $stable(st_q.r[r].value));
    end
endmodule

// File: rtl/ts_station.sv
module ts_station #(
    parameter int NUM_ENTRIES = tagsched_pkg::TS_NUM_ENTRIES,
    parameter int NUM_TAGS    = tagsched_pkg::TS_NUM_TAGS,
    parameter int DATA_W      = tagsched_pkg::TS_DATA_W,
    parameter int OP_W        = tagsched_pkg::TS_OP_W,
    parameter int NUM_SRC     = tagsched_pkg::TS_NUM_SRC,
    parameter int TAG_W       = $clog2(NUM_TAGS),
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_op,
    input  logic [TAG_W-1:0]  wr_dtag,
    input  logic              wr_ready [NUM_SRC],
    input  logic [TAG_W-1:0]  wr_tag   [NUM_SRC],
    input  logic [DATA_W-1:0] wr_value [NUM_SRC],
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              fu_ready,
    output logic              full,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dtag,
    output logic [DATA_W-1:0] iss_value [NUM_SRC]
);
    typedef struct packed {
        logic              ready;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } opnd_t;

    typedef struct packed {
        logic                     valid;
        logic [OP_W-1:0]          op;
        logic [TAG_W-1:0]         dtag;
        opnd_t [NUM_SRC-1:0]      src;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] e;
    } rs_state_t;

    rs_state_t st_q, st_d;

    logic [NUM_ENTRIES-1:0] ready_vec;
    logic [IDX_W-1:0]       slot;
    logic                   any_slot;
    logic [IDX_W-1:0]       pick;
    logic                   any_ready;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_rdy
        logic [NUM_SRC-1:0] ops_ok;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_op
            assign ops_ok[s] = st_q.e[e].src[s].ready;
        end
        assign ready_vec[e] = st_q.e[e].valid && (&ops_ok);
    end

    always_comb begin
        slot      = '0;
        any_slot  = 1'b0;
        pick      = '0;
        any_ready = 1'b0;
        for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
            if (!st_q.e[e].valid) begin
                slot     = IDX_W'(e);
                any_slot = 1'b1;
            end
            if (ready_vec[e]) begin
                pick      = IDX_W'(e);
                any_ready = 1'b1;
            end
        end
    end

    assign full      = !any_slot;
    assign iss_valid = fu_ready && any_ready;
    assign iss_op    = st_q.e[pick].op;
    assign iss_dtag  = st_q.e[pick].dtag;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_iss
        assign iss_value[s] = st_q.e[pick].src[s].value;
    end

    always_comb begin
        st_d = st_q;
        // wakeup from the result broadcast
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (bc_valid && st_q.e[e].valid && !st_q.e[e].src[s].ready
                    && (st_q.e[e].src[s].tag == bc_tag)) begin
                    st_d.e[e].src[s].ready = 1'b1;
                    st_d.e[e].src[s].value = bc_value;
                end
            end
        end
        if (iss_valid) st_d.e[pick].valid = 1'b0;
        if (wr_en) begin
            st_d.e[slot].valid = 1'b1;
            st_d.e[slot].op    = wr_op;
            st_d.e[slot].dtag  = wr_dtag;
            for (int s = 0; s < NUM_SRC; s++) begin
                st_d.e[slot].src[s].ready = wr_ready[s];
                st_d.e[slot].src[s].tag   = wr_tag[s];
                st_d.e[slot].src[s].value = wr_value[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: no write into a full station
    assert_no_write_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> any_slot);
    // R8: the issued entry is released
    assert_issue_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !st_q.e[$past(pick)].valid);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_wake_chk
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
            // R5: matching waiting operand captures the broadcast
            assert_wakeup_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (bc_valid && st_q.e[e].valid && !st_q.e[e].src[s].ready && st_q.e[e].src[s].tag == bc_tag)
                |=> (st_q.e[e].src[s].ready && st_q.e[e].src[s].value == $past(bc_value)));
        end
    end
endmodule

// File: rtl/tagsched_station.sv
module tagsched_station #(
    parameter int NUM_ENTRIES = tagsched_pkg::TS_NUM_ENTRIES,
    parameter int NUM_TAGS    = tagsched_pkg::TS_NUM_TAGS,
    parameter int NUM_REGS    = tagsched_pkg::TS_NUM_REGS,
    parameter int DATA_W      = tagsched_pkg::TS_DATA_W,
    parameter int OP_W        = tagsched_pkg::TS_OP_W,
    parameter int TAG_W       = $clog2(NUM_TAGS),
    parameter int REG_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [REG_W-1:0]  disp_dst,
    input  logic [REG_W-1:0]  disp_src_a,
    input  logic [REG_W-1:0]  disp_src_b,
    output logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              bcast_valid,
    input  logic [TAG_W-1:0]  bcast_tag,
    input  logic [DATA_W-1:0] bcast_value,
    input  logic              fu_ready,
    output logic              issue_valid,
    output logic [OP_W-1:0]   issue_op,
    output logic [TAG_W-1:0]  issue_tag,
    output logic [DATA_W-1:0] issue_a,
    output logic [DATA_W-1:0] issue_b,
    input  logic [REG_W-1:0]  look_idx,
    output logic              look_ready,
    output logic [TAG_W-1:0]  look_tag,
    output logic [DATA_W-1:0] look_value
);
    localparam int NUM_SRC = tagsched_pkg::TS_NUM_SRC;

    logic              accept;
    logic              pool_avail;
    logic              rs_full;
    logic [REG_W-1:0]  src_idx   [NUM_SRC];
    logic              src_ready [NUM_SRC];
    logic [TAG_W-1:0]  src_tag   [NUM_SRC];
    logic [DATA_W-1:0] src_value [NUM_SRC];
    logic [DATA_W-1:0] iss_value [NUM_SRC];

    assign disp_ready = pool_avail && !rs_full;
    assign accept     = disp_valid && disp_ready;
    assign src_idx[0] = disp_src_a;
    assign src_idx[1] = disp_src_b;
    assign issue_a    = iss_value[0];
    assign issue_b    = iss_value[1];

    ts_tag_pool #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_en  (accept),
        .give_en  (bcast_valid),
        .give_tag (bcast_tag),
        .any_free (pool_avail),
        .next_tag (disp_tag)
    );

    ts_reg_status #(
        .NUM_REGS(NUM_REGS), .NUM_TAGS(NUM_TAGS), .DATA_W(DATA_W),
        .NUM_SRC(NUM_SRC), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_idx    (src_idx),
        .src_ready  (src_ready),
        .src_tag    (src_tag),
        .src_value  (src_value),
        .ren_en     (accept),
        .ren_idx    (disp_dst),
        .ren_tag    (disp_tag),
        .bc_valid   (bcast_valid),
        .bc_tag     (bcast_tag),
        .bc_value   (bcast_value),
        .look_idx   (look_idx),
        .look_ready (look_ready),
        .look_tag   (look_tag),
        .look_value (look_value)
    );

    ts_station #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_TAGS(NUM_TAGS), .DATA_W(DATA_W),
        .OP_W(OP_W), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W)
    ) u_rs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_op     (disp_op),
        .wr_dtag   (disp_tag),
        .wr_ready  (src_ready),
        .wr_tag    (src_tag),
        .wr_value  (src_value),
        .bc_valid  (bcast_valid),
        .bc_tag    (bcast_tag),
        .bc_value  (bcast_value),
        .fu_ready  (fu_ready),
        .full      (rs_full),
        .iss_valid (issue_valid),
        .iss_op    (issue_op),
        .iss_dtag  (issue_tag),
        .iss_value (iss_value)
    );

    // R8: nothing issues while the function unit is busy
    assert_issue_needs_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fu_ready |-> !issue_valid);
endmodule

// File: tb/tagsched_station_test.sv
module tagsched_station_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid;
    logic [3:0]  disp_op;
    logic [2:0]  disp_dst, disp_src_a, disp_src_b;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        bcast_valid;
    logic [2:0]  bcast_tag;
    logic [31:0] bcast_value;
    logic        fu_ready;
    logic        issue_valid;
    logic [3:0]  issue_op;
    logic [2:0]  issue_tag;
    logic [31:0] issue_a, issue_b;
    logic [2:0]  look_idx;
    logic        look_ready;
    logic [2:0]  look_tag;
    logic [31:0] look_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [31:0] ref_reg [8];

    always #5 clk = ~clk;

    tagsched_station uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value),
        .fu_ready(fu_ready), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_tag(issue_tag), .issue_a(issue_a), .issue_b(issue_b),
        .look_idx(look_idx), .look_ready(look_ready), .look_tag(look_tag),
        .look_value(look_value)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  dst;
        logic [2:0]  sa;
        logic [2:0]  sb;
        logic [31:0] res;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{op: 4'd1, dst: 3'd1, sa: 3'd0, sb: 3'd0, res: 32'h11},
        '{op: 4'd2, dst: 3'd2, sa: 3'd1, sb: 3'd0, res: 32'h22},
        '{op: 4'd3, dst: 3'd3, sa: 3'd1, sb: 3'd2, res: 32'h33},
        '{op: 4'd4, dst: 3'd1, sa: 3'd1, sb: 3'd3, res: 32'h44},
        '{op: 4'd5, dst: 3'd4, sa: 3'd1, sb: 3'd1, res: 32'h55},
        '{op: 4'd6, dst: 3'd0, sa: 3'd4, sb: 3'd2, res: 32'h66}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic offer(input logic [3:0] op, input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
        disp_valid = 1'b1; disp_op = op; disp_dst = d; disp_src_a = a; disp_src_b = b;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; disp_valid = 0; disp_op = 0; disp_dst = 0; disp_src_a = 0; disp_src_b = 0;
        bcast_valid = 0; bcast_tag = 0; bcast_value = 0; fu_ready = 0; look_idx = 0;
        for (int i = 0; i < 8; i++) ref_reg[i] = 32'h0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        fu_ready = 1'b1;
        #1;
        check("R1 disp_ready", 32'(disp_ready), 32'd1);
        check("R1 disp_tag", 32'(disp_tag), 32'd0);
        check("R1 issue_valid", 32'(issue_valid), 32'd0);
        for (int r = 0; r < 8; r++) begin
            look_idx = 3'(r);
            #1;
            check("R1 reg ready", 32'(look_ready), 32'd1);
            check("R1 reg value", look_value, 32'd0);
        end
        fu_ready = 1'b0;

        // vector table: dispatch, issue, broadcast, read back (R2 R3 R4 R7 R8)
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            offer(VECS[v].op, VECS[v].dst, VECS[v].sa, VECS[v].sb);
            #1;
            check("R2 tag offered", 32'(disp_tag), 32'd0);
            @(negedge clk);
            disp_valid = 1'b0; fu_ready = 1'b1; look_idx = VECS[v].dst;
            #1;
            check("R3 dst pending", 32'(look_ready), 32'd0);
            check("R3 dst tag", 32'(look_tag), 32'd0);
            check("R8 issue valid", 32'(issue_valid), 32'd1);
            check("R8 issue op", 32'(issue_op), 32'(VECS[v].op));
            check("R4 operand a", issue_a, ref_reg[VECS[v].sa]);
            check("R4 operand b", issue_b, ref_reg[VECS[v].sb]);
            @(negedge clk);
            fu_ready = 1'b0;
            bcast_valid = 1'b1; bcast_tag = 3'd0; bcast_value = VECS[v].res;
            @(negedge clk);
            bcast_valid = 1'b0;
            ref_reg[VECS[v].dst] = VECS[v].res;
            #1;
            check("R7 written back", look_value, VECS[v].res);
            check("R7 ready again", 32'(look_ready), 32'd1);
        end

        // R5 dependent wakeup
        @(negedge clk);
        offer(4'd7, 3'd1, 3'd0, 3'd0);
        #1; check("R2 first tag", 32'(disp_tag), 32'd0);
        @(negedge clk);
        offer(4'd8, 3'd2, 3'd1, 3'd3);
        #1; check("R2 next lowest tag", 32'(disp_tag), 32'd1);
        @(negedge clk);
        disp_valid = 1'b0; fu_ready = 1'b1;
        #1; check("R8 producer issues", 32'(issue_tag), 32'd0);
        @(negedge clk);
        bcast_valid = 1'b1; bcast_tag = 3'd0; bcast_value = 32'hA5;
        #1; check("R5 consumer still waits", 32'(issue_valid), 32'd0);
        @(negedge clk);
        bcast_valid = 1'b0; look_idx = 3'd1;
        #1;
        check("R5 consumer issues", 32'(issue_valid), 32'd1);
        check("R5 consumer tag", 32'(issue_tag), 32'd1);
        check("R5 woken operand", issue_a, 32'hA5);
        check("R4 ready operand", issue_b, 32'h33);
        check("R7 matching write", look_value, 32'hA5);
        @(negedge clk);
        fu_ready = 1'b0; bcast_valid = 1'b1; bcast_tag = 3'd1; bcast_value = 32'hB6;
        @(negedge clk);
        bcast_valid = 1'b0;

        // R7 stale tag: r3 renamed twice
        offer(4'd1, 3'd3, 3'd0, 3'd0);
        @(negedge clk);
        offer(4'd2, 3'd3, 3'd0, 3'd0);
        @(negedge clk);
        disp_valid = 1'b0; fu_ready = 1'b1;
        #1; check("R8 lowest entry first", 32'(issue_tag), 32'd0);
        @(negedge clk);
        #1; check("R8 second entry", 32'(issue_tag), 32'd1);
        @(negedge clk);
        fu_ready = 1'b0; bcast_valid = 1'b1; bcast_tag = 3'd0; bcast_value = 32'hAA;
        @(negedge clk);
        bcast_valid = 1'b0; look_idx = 3'd3;
        #1;
        check("R7 stale result ignored", 32'(look_ready), 32'd0);
        check("R7 newer tag kept", 32'(look_tag), 32'd1);
        check("R7 tag back in pool", 32'(disp_tag), 32'd0);
        @(negedge clk);
        bcast_valid = 1'b1; bcast_tag = 3'd1; bcast_value = 32'hBB;
        @(negedge clk);
        bcast_valid = 1'b0;
        #1;
        check("R7 newest result", look_value, 32'hBB);
        check("R7 newest ready", 32'(look_ready), 32'd1);

        // R6 dispatch reads a tag broadcast in the same cycle
        @(negedge clk);
        offer(4'd3, 3'd4, 3'd0, 3'd0);
        @(negedge clk);
        disp_valid = 1'b0; fu_ready = 1'b1;
        #1; check("R8 issue before bypass", 32'(issue_tag), 32'd0);
        @(negedge clk);
        fu_ready = 1'b0;
        offer(4'd9, 3'd5, 3'd4, 3'd2);
        bcast_valid = 1'b1; bcast_tag = 3'd0; bcast_value = 32'h77;
        #1; check("R2 busy tag skipped", 32'(disp_tag), 32'd1);
        @(negedge clk);
        disp_valid = 1'b0; bcast_valid = 1'b0; fu_ready = 1'b1;
        #1;
        check("R6 issues next cycle", 32'(issue_valid), 32'd1);
        check("R6 bypassed operand", issue_a, 32'h77);
        check("R6 other operand", issue_b, 32'hB6);
        @(negedge clk);
        fu_ready = 1'b0; bcast_valid = 1'b1; bcast_tag = 3'd1; bcast_value = 32'h5A;
        @(negedge clk);
        bcast_valid = 1'b0;

        // R10 rename and old-tag broadcast on the same register
        offer(4'd4, 3'd6, 3'd0, 3'd0);
        @(negedge clk);
        disp_valid = 1'b0; fu_ready = 1'b1;
        @(negedge clk);
        fu_ready = 1'b0;
        offer(4'd5, 3'd6, 3'd0, 3'd0);
        bcast_valid = 1'b1; bcast_tag = 3'd0; bcast_value = 32'h99;
        @(negedge clk);
        disp_valid = 1'b0; bcast_valid = 1'b0; look_idx = 3'd6;
        #1;
        check("R10 rename wins ready", 32'(look_ready), 32'd0);
        check("R10 rename wins tag", 32'(look_tag), 32'd1);
        fu_ready = 1'b1;
        @(negedge clk);
        fu_ready = 1'b0; bcast_valid = 1'b1; bcast_tag = 3'd1; bcast_value = 32'h3C;
        @(negedge clk);
        bcast_valid = 1'b0;
        #1; check("R10 later result lands", look_value, 32'h3C);

        // R9 full station, then empty pool
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            offer(4'(i), 3'd7, 3'd0, 3'd0);
            #1; check("R2 tags in order", 32'(disp_tag), 32'(i));
        end
        @(negedge clk);
        disp_valid = 1'b0;
        #1;
        check("R9 stall when full", 32'(disp_ready), 32'd0);
        check("R8 no issue while unit busy", 32'(issue_valid), 32'd0);
        offer(4'd15, 3'd0, 3'd0, 3'd0);
        @(negedge clk);
        disp_valid = 1'b0; look_idx = 3'd0;
        #1;
        check("R9 ignored dispatch ready", 32'(look_ready), 32'd1);
        check("R9 ignored dispatch value", look_value, 32'h66);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fu_ready = 1'b1;
            #1; check("R8 drain order", 32'(issue_tag), 32'(i));
        end
        @(negedge clk);
        fu_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            offer(4'(i), 3'd7, 3'd0, 3'd0);
            #1; check("R2 upper tags", 32'(disp_tag), 32'(4 + i));
            @(negedge clk);
        end
        disp_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            fu_ready = 1'b1;
            #1; check("R8 upper drain", 32'(issue_tag), 32'(4 + i));
            @(negedge clk);
        end
        fu_ready = 1'b0;
        #1;
        check("R9 stall when pool empty", 32'(disp_ready), 32'd0);
        for (int i = 0; i < 8; i++) begin
            bcast_valid = 1'b1; bcast_tag = 3'(i); bcast_value = 32'h100 + 32'(i);
            @(negedge clk);
        end
        bcast_valid = 1'b0; look_idx = 3'd7;
        #1;
        check("R7 final owner writes", look_value, 32'h107);
        check("R9 ready after refill", 32'(disp_ready), 32'd1);

        finish_run();
    end
endmodule